// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two strobes that an 8051-style processor places on its external memory bus: an active-high address latch pulse (`ale`) and an active-low code-read strobe (`psen_n`). Everything is timed from the oscillator clock. One machine cycle is twelve oscillator periods and is split into two halves of six. Each half carries one address latch pulse and, when code is fetched from outside, one code-read pulse. When a machine cycle is flagged as an external data access, the code-read pulses and the latch pulse of the second half are left out.

A one-bit control register selects the quiet-latch mode. In that mode the latch line is held high (a weak pull-up, modelled as a constant 1) instead of pulsing. The mode gives way when a data-move or code-read instruction is running, and it has no effect in external-execution mode. The reset pin is qualified: only a high level held for two full machine cycles resets the block. Instruction decode and the address and data multiplexing are handled elsewhere. The block takes the per-cycle flags from the core and latches them at each machine-cycle boundary.

The sequencer is a small state machine. `ST_RESET` holds both strobes inactive and the phase at zero. `ST_FETCH` is an ordinary machine cycle. `ST_XDATA` is an external data access cycle. The transitions are: RESET→FETCH or RESET→XDATA on the first clock after the qualified reset ends; FETCH/XDATA→FETCH or FETCH/XDATA→XDATA at every boundary (phase 11), chosen by the data-access flag; any state→RESET while the qualified reset is active.

Top module: `bus_strobe_gen`

## Requirements
- R1: The block resets only after `rst_pin` has been high for 24 consecutive clocks. A shorter high pulse leaves the phase sequence and the strobes undisturbed.
- R2: While reset is active, `ale` is 0 and `psen_n` is 1. Reset stays active for one clock after `rst_pin` falls. On the clock after that, phase 0 of a new machine cycle begins.
- R3: Phases run 0 to 11 and then wrap. In an ordinary cycle with the latch enabled, `ale` is high for exactly phases 0–1 and 6–7.
- R4: In an external data cycle with the latch enabled, `ale` is high only in phases 0–1, so the second-half pulse is skipped.
- R5: `xdata_cycle`, `movx_instr` and `ext_exec` are sampled on the clock edge that ends phase 11, or on the first edge after reset. They then govern the whole of the next machine cycle.
- R6: The quiet-latch bit is bit 0 of the register at address 0x8E. When it is 1 and both `movx_instr` and `ext_exec` are 0, `ale` stays at 1 for the entire machine cycle.
- R7: When the quiet-latch bit is 1, a machine cycle with `movx_instr` or `ext_exec` set still pulses `ale` exactly as in R3 or R4.
- R8: In an ordinary cycle with `ext_exec` set, `psen_n` is low in phases 3–5 and 9–11 and high elsewhere. It never goes low together with `ale`. With `ext_exec` clear, `psen_n` stays high.
- R9: In an external data cycle, `psen_n` stays high for all twelve phases, so both code-read pulses are skipped.
- R10: Address 0x8E reads back bit 0 as written, with bits 7..1 reading 0. Every other address reads 0 and ignores writes. Reset clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high, qualified internally |
| xdata_cycle | input | 1 | Next machine cycle is an external data access |
| movx_instr | input | 1 | Next machine cycle belongs to a data-move or code-read instruction |
| ext_exec | input | 1 | Code is executed from external program memory |
| cfg_addr | input | 8 | Control register address |
| cfg_wdata | input | 8 | Control register write data |
| cfg_we | input | 1 | Control register write enable |
| cfg_rdata | output | 8 | Control register read data (combinational) |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code-read strobe, active low |

## Verification
The strobes are exercised with the following patterns:
- Ordinary cycles with internal execution, then with external execution. Comparing the two separates latch pulsing from code-read pulsing.
- External data cycles mixed in among them. These show which pulses are dropped, and that only the second-half latch pulse goes.
- A data-access flag raised only on the last phase of a cycle. This confirms the flags are sampled at the boundary.
- Quiet-latch mode with neither override, with the instruction override, and with external execution. These separate the constant-high level from the override paths.
- A short reset pulse, to distinguish the qualified reset from a raw one.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_FETCH = 2'd1,
        ST_XDATA = 2'd2
    } mc_state_e;
endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
    parameter int CYCLES = 24
) (
    input  logic clk,
    input  logic rst_pin,
    output logic core_rst
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LIM = W'(CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_pin)
            cnt <= '0;
        else if (cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign core_rst = (cnt == LIM);
endmodule

// File: rtl/aux_reg.sv
module aux_reg #(
    parameter int          AW   = 8,
    parameter int          DW   = 8,
    parameter logic [AW-1:0] ADDR = 8'h8E
) (
    input  logic          clk,
    input  logic          core_rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          we,
    output logic [DW-1:0] rdata,
    output logic          quiet
);
    logic hit;
    assign hit = (addr == ADDR);

    always_ff @(posedge clk) begin
        if (core_rst)
            quiet <= 1'b0;
        else if (we && hit)
            quiet <= wdata[0];
    end

    always_comb begin
        rdata = '0;
        if (hit)
            rdata[0] = quiet;
    end
endmodule

// File: rtl/cycle_seq.sv
module cycle_seq
    import strobe_pkg::*;
#(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          core_rst,
    input  logic          xdata_cycle,
    input  logic          movx_instr,
    input  logic          ext_exec,
    input  logic          quiet,
    output mc_state_e     state,
    output logic [PW-1:0] phase,
    output logic          ale_en,
    output logic          ext_q
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    mc_state_e nxt;
    logic      boundary;

    assign boundary = (state == ST_RESET) || (phase == LAST);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET: nxt = xdata_cycle ? ST_XDATA : ST_FETCH;
            ST_FETCH,
            ST_XDATA: if (boundary) nxt = xdata_cycle ? ST_XDATA : ST_FETCH;
            default:  nxt = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (core_rst)
            state <= ST_RESET;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (core_rst || state == ST_RESET)
            phase <= '0;
        else if (phase == LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (core_rst) begin
            ale_en <= 1'b0;
            ext_q  <= 1'b0;
        end else if (boundary) begin
            ale_en <= !quiet || ext_exec || movx_instr;
            ext_q  <= ext_exec;
        end
    end
endmodule

// File: rtl/strobe_dec.sv
module strobe_dec
    import strobe_pkg::*;
#(
    parameter int PHASES    = 12,
    parameter int ALE_W     = 2,
    parameter int PSEN_LEAD = 3,
    parameter int PSEN_W    = 3,
    localparam int PW = $clog2(PHASES)
) (
    input  mc_state_e     state,
    input  logic [PW-1:0] phase,
    input  logic          ale_en,
    input  logic          ext_q,
    output logic          ale,
    output logic          psen_n
);
    localparam int HALF = PHASES / 2;
    localparam logic [PW-1:0] HALF_P = PW'(HALF);
    localparam logic [PW-1:0] ALE_END = PW'(ALE_W);
    localparam logic [PW-1:0] PS_BEG  = PW'(PSEN_LEAD);
    localparam logic [PW-1:0] PS_END  = PW'(PSEN_LEAD + PSEN_W);

    logic          second;
    logic [PW-1:0] in_half;
    logic          ale_slot;
    logic          psen_slot;

    assign second    = (phase >= HALF_P);
    assign in_half   = second ? phase - HALF_P : phase;
    assign ale_slot  = (in_half < ALE_END);
    assign psen_slot = (in_half >= PS_BEG) && (in_half < PS_END);

    always_comb begin
        ale    = 1'b0;
        psen_n = 1'b1;
        unique case (state)
            ST_RESET: begin
                ale    = 1'b0;
                psen_n = 1'b1;
            end
            ST_FETCH: begin
                ale    = ale_en ? ale_slot : 1'b1;
                psen_n = !(ext_q && psen_slot);
            end
            ST_XDATA: begin
                ale    = ale_en ? (ale_slot && !second) : 1'b1;
                psen_n = 1'b1;
            end
            default: begin
                ale    = 1'b0;
                psen_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import strobe_pkg::*;
#(
    parameter int          PHASES    = 12,
    parameter int          RST_MC    = 2,
    parameter int          ALE_W     = 2,
    parameter int          PSEN_LEAD = 3,
    parameter int          PSEN_W    = 3,
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [AW-1:0] AUX_ADDR = 8'h8E
) (
    input  logic          clk,
    input  logic          rst_pin,
    input  logic          xdata_cycle,
    input  logic          movx_instr,
    input  logic          ext_exec,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          cfg_we,
    output logic [DW-1:0] cfg_rdata,
    output logic          ale,
    output logic          psen_n
);
    localparam int PW = $clog2(PHASES);

    logic          core_rst;
    logic          quiet;
    mc_state_e     st;
    logic [PW-1:0] ph;
    logic          ale_en;
    logic          ext_q;

    rst_qual #(.CYCLES(RST_MC * PHASES)) u_rst (
        .clk     (clk),
        .rst_pin (rst_pin),
        .core_rst(core_rst)
    );

    aux_reg #(.AW(AW), .DW(DW), .ADDR(AUX_ADDR)) u_aux (
        .clk     (clk),
        .core_rst(core_rst),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .we      (cfg_we),
        .rdata   (cfg_rdata),
        .quiet   (quiet)
    );

    cycle_seq #(.PHASES(PHASES)) u_seq (
        .clk        (clk),
        .core_rst   (core_rst),
        .xdata_cycle(xdata_cycle),
        .movx_instr (movx_instr),
        .ext_exec   (ext_exec),
        .quiet      (quiet),
        .state      (st),
        .phase      (ph),
        .ale_en     (ale_en),
        .ext_q      (ext_q)
    );

    strobe_dec #(
        .PHASES(PHASES), .ALE_W(ALE_W),
        .PSEN_LEAD(PSEN_LEAD), .PSEN_W(PSEN_W)
    ) u_dec (
        .state (st),
        .phase (ph),
        .ale_en(ale_en),
        .ext_q (ext_q),
        .ale   (ale),
        .psen_n(psen_n)
    );
endmodule

// File: rtl/strobe_chk.sv
module strobe_chk
    import strobe_pkg::*;
#(
    parameter int PHASES = 12,
    localparam int PW = $clog2(PHASES)
) (
    input logic          clk,
    input logic          rst_pin,
    input logic          core_rst,
    input logic          ale,
    input logic          psen_n,
    input mc_state_e     state,
    input logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    // R2: after any edge in qualified reset, both strobes are inactive
    a_r2_reset_quiet: assert property (@(posedge clk)
        core_rst |=> (!ale && psen_n));

    // R3: an address latch pulse is never a single clock wide
    a_r3_ale_two_wide: assert property (@(posedge clk) disable iff (rst_pin || core_rst)
        $rose(ale) |=> ale);

    // R3: phase advances by one inside a machine cycle
    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst_pin || core_rst)
        (state != ST_RESET && phase != LAST) |=> (phase == $past(phase) + 1'b1));

    // R8: a code-read pulse lasts more than one clock
    a_r8_psen_wide: assert property (@(posedge clk) disable iff (rst_pin || core_rst)
        $fell(psen_n) |=> !psen_n);

    // R8: code read and address latch never overlap
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst_pin || core_rst)
        !psen_n |-> !ale);

    // R9: no code read during an external data cycle
    a_r9_xdata_idle: assert property (@(posedge clk) disable iff (rst_pin || core_rst)
        (state == ST_XDATA) |-> psen_n);
endmodule

bind bus_strobe_gen strobe_chk #(.PHASES(PHASES)) u_chk (
    .clk     (clk),
    .rst_pin (rst_pin),
    .core_rst(core_rst),
    .ale     (ale),
    .psen_n  (psen_n),
    .state   (st),
    .phase   (ph)
);

// File: tb/tb_bus_strobe_gen.sv
`timescale 1ns/1ps
module tb_bus_strobe_gen;
    logic       clk = 1'b0;
    logic       rst_pin = 1'b1;
    logic       xdata_cycle = 1'b0;
    logic       movx_instr = 1'b0;
    logic       ext_exec = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_rdata;
    logic       ale;
    logic       psen_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bus_strobe_gen dut (
        .clk(clk), .rst_pin(rst_pin), .xdata_cycle(xdata_cycle),
        .movx_instr(movx_instr), .ext_exec(ext_exec),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
        .cfg_rdata(cfg_rdata), .ale(ale), .psen_n(psen_n)
    );

    // Behavioural reference: 0 = reset, 1 = ordinary, 2 = external data
    int  m_cnt = 0;
    int  m_st  = 0;
    int  m_ph  = 0;
    bit  m_en  = 0;
    bit  m_ext = 0;
    bit  m_dis = 0;
    bit  armed = 0;

    always @(posedge clk) begin
        bit core;
        bit bnd;
        bit old_dis;
        core    = (m_cnt == 24);
        old_dis = m_dis;
        if (core) begin
            m_st = 0; m_ph = 0; m_en = 0; m_ext = 0; m_dis = 0;
            armed = 1;
        end else begin
            bnd = (m_st == 0) || (m_ph == 11);
            if (m_st != 0) m_ph = (m_ph == 11) ? 0 : m_ph + 1;
            if (bnd) begin
                m_st  = xdata_cycle ? 2 : 1;
                m_en  = !old_dis || ext_exec || movx_instr;
                m_ext = ext_exec;
            end
            if (cfg_we && cfg_addr == 8'h8E) m_dis = cfg_wdata[0];
        end
        if (!rst_pin) m_cnt = 0;
        else if (m_cnt < 24) m_cnt = m_cnt + 1;
    end

    function automatic bit exp_ale();
        int h = m_ph % 6;
        if (m_st == 0) return 1'b0;
        if (!m_en) return 1'b1;
        if (m_st == 2) return (m_ph < 2);
        return (h < 2);
    endfunction

    function automatic bit exp_psen_n();
        int h = m_ph % 6;
        if (m_st != 1) return 1'b1;
        return !(m_ext && h >= 3 && h < 6);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        string tag_a;
        string tag_p;
        if (armed) begin
            if (m_st == 0)            begin tag_a = "R2"; tag_p = "R2"; end
            else if (rst_pin)         begin tag_a = "R1"; tag_p = "R1"; end
            else if (m_st == 2)       begin tag_a = m_en ? "R4" : "R6"; tag_p = "R9"; end
            else                      begin tag_a = !m_en ? "R6" : (m_dis ? "R7" : "R3"); tag_p = "R8"; end
            check(tag_a, {7'b0, ale}, {7'b0, exp_ale()});
            check(tag_p, {7'b0, psen_n}, {7'b0, exp_psen_n()});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input int k);
        while (!(m_st != 0 && m_ph == k)) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(30);
        // R2: reset state seen at the ports
        check("R2", {6'b0, ale, psen_n}, 8'h01);
        cfg_addr = 8'h8E;
        tick(1);
        check("R10", cfg_rdata, 8'h00);
        rst_pin = 1'b0;
        tick(1);
        check("R2", {7'b0, ale}, 8'h00);
        tick(1);
        check("R2", {7'b0, ale}, 8'h01);

        tick(36);                          // ordinary cycles, internal code
        ext_exec = 1'b1;
        tick(48);                          // external code fetch (R8)
        xdata_cycle = 1'b1;
        tick(24);                          // external data cycles (R4, R9)
        xdata_cycle = 1'b0;
        tick(24);

        // R5: flag raised only while phase 11 ends
        wait_phase(11);
        xdata_cycle = 1'b1;
        tick(1);
        xdata_cycle = 1'b0;
        wait_phase(7);
        check("R5", {7'b0, ale}, 8'h00);
        tick(1);
        wait_phase(7);
        check("R5", {7'b0, ale}, 8'h01);

        // R10: register readback and address decode
        wr(8'h8E, 8'hFF);
        cfg_addr = 8'h8E; tick(1);
        check("R10", cfg_rdata, 8'h01);
        wr(8'h8F, 8'h00);
        cfg_addr = 8'h8F; tick(1);
        check("R10", cfg_rdata, 8'h00);
        cfg_addr = 8'h8E; tick(1);
        check("R10", cfg_rdata, 8'h01);

        // R7: external execution overrides the quiet bit
        tick(36);
        // R6: quiet latch with no override
        ext_exec = 1'b0;
        tick(14);
        wait_phase(4);
        check("R6", {7'b0, ale}, 8'h01);
        tick(30);
        // R7: instruction override
        movx_instr = 1'b1;
        tick(14);
        wait_phase(4);
        check("R7", {7'b0, ale}, 8'h00);
        tick(30);
        movx_instr = 1'b0;
        tick(24);

        // R1: short reset pulse is ignored
        wr(8'h8E, 8'h00);
        rst_pin = 1'b1;
        tick(10);
        rst_pin = 1'b0;
        tick(2);
        cfg_addr = 8'h8E;
        wr(8'h8E, 8'h01);
        rst_pin = 1'b1;
        tick(20);
        rst_pin = 1'b0;
        tick(1);
        check("R1", cfg_rdata, 8'h01);
        tick(24);

        // R10: qualified reset clears the bit
        rst_pin = 1'b1;
        tick(26);
        rst_pin = 1'b0;
        tick(2);
        check("R10", cfg_rdata, 8'h00);
        tick(24);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule